// File: doc/BRIEF.md
# Four-Domain Programmable Clock Enable Divider

This block turns a handful of reference tick strobes into four divided clock enables: one for the processor, two for system buses (bus 0 and bus 2) and one for the peripheral bus. It runs entirely in the fast system clock. Every reference source (PLL A, PLL M, PLL E, the external crystal and the real-time clock) appears as a one-cycle strobe that marks a rising edge of that source. Each domain picks a source and counts its strobes down by a programmable ratio. It then raises its enable for one system cycle per divided period.

All settings live in one 32-bit control word, and the whole word is written at once. A two-level source tree applies. A main selector picks among PLL A, the crystal and the real-time clock. The processor and bus 0 domains choose among that main clock, PLL M and PLL E. Bus 2 chooses among the main clock, PLL M and the real-time clock. The peripheral domain has no selector and always takes the bus 2 choice, while keeping its own divider. Two divider codes are reserved: one halts a domain and one runs it at full source rate. The divider fields only take a new value when the write also sets the change-enable bit. A new ratio takes effect at the next period boundary of its domain, so no enable period is ever cut short.

Top module: `clk_div_bank`

## Requirements
- R1: After reset the control word reads 32'hAA00_0000: all four divider codes are 0, all four source fields are 2, the change-enable bit is 0, and no domain enable is high.
- R2: Field positions: divider codes at [3:0] processor, [11:8] bus 0, [15:12] bus 2, [19:16] peripheral; change enable at [22]; source codes at [31:30] main, [29:28] processor, [27:26] bus 0, [25:24] bus 2. All other bits read 0 whatever is written.
- R3: A write with bit 22 clear leaves all four divider codes unchanged. The divider ratios seen at domEn stay as they were. The source fields and bit 22 always take the written value.
- R4: A divider code c from 0 to 13 gives one enable per c+1 source strobes. domEn[d] is high for exactly the one cycle after the strobe that completes the period, and is low in every other cycle.
- R5: Divider code 14 stops the domain: its enable stays low regardless of strobes.
- R6: Divider code 15 resumes the domain at ratio one: every source strobe produces an enable in the following cycle.
- R7: Main source code 1 selects PLL A, code 2 the crystal, code 3 the real-time clock, and code 0 gives no strobes.
- R8: Processor and bus 0 source code 1 selects the main clock, code 2 PLL M, code 3 PLL E, and code 0 gives no strobes.
- R9: Bus 2 source code 1 selects the main clock, code 2 PLL M, code 3 the real-time clock, and code 0 gives none. The peripheral domain (domEn[3]) uses the bus 2 source with its own divider code.
- R10: A new divider code is applied at the strobe that ends the current period, and the next period uses it. A stopped domain (code 14) takes a new code in the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes and enables are synchronous to it |
| rstN | input | 1 | Active-low synchronous reset |
| refPllA | input | 1 | Tick strobe of PLL A |
| refExt | input | 1 | Tick strobe of the external crystal |
| refRtc | input | 1 | Tick strobe of the real-time clock |
| refPllM | input | 1 | Tick strobe of PLL M |
| refPllE | input | 1 | Tick strobe of PLL E |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Current control word |
| domEn | output | 4 | Domain enables: [0] processor, [1] bus 0, [2] bus 2, [3] peripheral |

## Verification
A wrong stored divider code or a wrong source decode shows at domEn within one divided period. The enable either comes at the wrong strobe or comes from the wrong reference, so the bench drives each reference on its own with distinct strobe patterns. A period counter that is off by one shifts every later enable of its domain, which a cycle-exact comparison against the expected pulse train catches on the first boundary. A divider field that changes when it should not shows at rdData in the cycle after the write. A code applied mid-period shows as a shortened period before the old one ends.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  parameter int REG_W   = 32;
  parameter int DIV_W   = 4;
  parameter int SEL_W   = 2;
  parameter int NUM_DOM = 4;

  localparam int DIV_STOP   = (1 << DIV_W) - 2;
  localparam int DIV_RESUME = (1 << DIV_W) - 1;

  // field positions decoded by the clock tree
  localparam int DIV_LSB_CPU = 0;
  localparam int DIV_LSB_B0  = 8;
  localparam int DIV_LSB_B2  = 12;
  localparam int DIV_LSB_PER = 16;
  localparam int CHG_BIT     = 22;
  localparam int SEL_LSB_MAIN = 30;
  localparam int SEL_LSB_CPU  = 28;
  localparam int SEL_LSB_B0   = 26;
  localparam int SEL_LSB_B2   = 24;

  localparam int DIV_LSB [NUM_DOM] = '{DIV_LSB_CPU, DIV_LSB_B0, DIV_LSB_B2, DIV_LSB_PER};

  localparam logic [REG_W-1:0] DIV_ONES = REG_W'((1 << DIV_W) - 1);
  localparam logic [REG_W-1:0] SEL_ONES = REG_W'((1 << SEL_W) - 1);
  localparam logic [REG_W-1:0] DIV_MASK =
    (DIV_ONES << DIV_LSB_CPU) | (DIV_ONES << DIV_LSB_B0) |
    (DIV_ONES << DIV_LSB_B2)  | (DIV_ONES << DIV_LSB_PER);
  localparam logic [REG_W-1:0] SEL_MASK =
    (SEL_ONES << SEL_LSB_MAIN) | (SEL_ONES << SEL_LSB_CPU) |
    (SEL_ONES << SEL_LSB_B0)   | (SEL_ONES << SEL_LSB_B2);
  localparam logic [REG_W-1:0] CHG_MASK = REG_W'(1) << CHG_BIT;
  localparam logic [REG_W-1:0] WR_MASK  = DIV_MASK | SEL_MASK | CHG_MASK;

  localparam logic [SEL_W-1:0] SEL_RESET = SEL_W'(2);
  localparam logic [REG_W-1:0] RESET_WORD =
    (REG_W'(SEL_RESET) << SEL_LSB_MAIN) | (REG_W'(SEL_RESET) << SEL_LSB_CPU) |
    (REG_W'(SEL_RESET) << SEL_LSB_B0)   | (REG_W'(SEL_RESET) << SEL_LSB_B2);

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_TWO  = 2'd2,
    SRC_THREE = 2'd3
  } srcSel_e;

  // strobes from control to datapath: one tick and one pending code per domain
  typedef struct packed {
    logic [NUM_DOM-1:0]            tick;
    logic [NUM_DOM-1:0][DIV_W-1:0] code;
  } divStrobe_t;
endpackage

// File: rtl/cdb_ctrl.sv
module cdb_ctrl
  import cdb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refPllA,
  input  logic             refExt,
  input  logic             refRtc,
  input  logic             refPllM,
  input  logic             refPllE,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctlWord,
  output divStrobe_t       strb
);
  logic [REG_W-1:0] ctlReg;
  logic [REG_W-1:0] nextWord;
  srcSel_e mainSel, cpuSel, b0Sel, b2Sel;
  logic mainTick, cpuTick, b0Tick, b2Tick;

  // divider codes only move when the write carries the change enable
  always_comb begin
    if (wrData[CHG_BIT])
      nextWord = wrData & WR_MASK;
    else
      nextWord = (wrData & WR_MASK & ~DIV_MASK) | (ctlReg & DIV_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      ctlReg <= RESET_WORD;
    else if (wrEn)
      ctlReg <= nextWord;
  end

  assign ctlWord = ctlReg;

  assign mainSel = srcSel_e'(ctlReg[SEL_LSB_MAIN +: SEL_W]);
  assign cpuSel  = srcSel_e'(ctlReg[SEL_LSB_CPU  +: SEL_W]);
  assign b0Sel   = srcSel_e'(ctlReg[SEL_LSB_B0   +: SEL_W]);
  assign b2Sel   = srcSel_e'(ctlReg[SEL_LSB_B2   +: SEL_W]);

  function automatic logic pickTick(input srcSel_e sel, input logic t1,
                                    input logic t2, input logic t3);
    logic r;
    unique case (sel)
      SRC_ONE:   r = t1;
      SRC_TWO:   r = t2;
      SRC_THREE: r = t3;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  always_comb begin
    mainTick = pickTick(mainSel, refPllA, refExt, refRtc);
    cpuTick  = pickTick(cpuSel, mainTick, refPllM, refPllE);
    b0Tick   = pickTick(b0Sel,  mainTick, refPllM, refPllE);
    b2Tick   = pickTick(b2Sel,  mainTick, refPllM, refRtc);
  end

  always_comb begin
    strb.tick[0] = cpuTick;
    strb.tick[1] = b0Tick;
    strb.tick[2] = b2Tick;
    strb.tick[3] = b2Tick;   // peripheral follows the bus 2 source
    for (int d = 0; d < NUM_DOM; d++)
      strb.code[d] = ctlReg[DIV_LSB[d] +: DIV_W];
  end

  assert_divhold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[CHG_BIT]) |=> $stable(ctlReg & DIV_MASK));

  assert_cpu_nosrc_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel == SRC_NONE) |-> !strb.tick[0]);

  assert_main_nosrc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mainSel == SRC_NONE && cpuSel == SRC_ONE) |-> !strb.tick[0]);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((ctlReg & ~WR_MASK) == '0));
endmodule

// File: rtl/cdb_div_slice.sv
module cdb_div_slice
  import cdb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTick,
  input  logic [DIV_W-1:0] pendCode,
  output logic             domEn
);
  localparam logic [DIV_W-1:0] STOP_CODE   = DIV_W'(DIV_STOP);
  localparam logic [DIV_W-1:0] RESUME_CODE = DIV_W'(DIV_RESUME);

  logic [DIV_W-1:0] actCode;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;
  logic             atLimit;
  logic             boundary;

  assign limit    = (actCode == RESUME_CODE) ? '0 : actCode;
  assign atLimit  = (cnt == limit);
  assign boundary = srcTick && (actCode != STOP_CODE) && atLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCode <= '0;
      cnt     <= '0;
      domEn   <= 1'b0;
    end else begin
      domEn <= boundary;
      if (actCode == STOP_CODE) begin
        actCode <= pendCode;
        cnt     <= '0;
      end else if (srcTick) begin
        if (atLimit) begin
          cnt     <= '0;
          actCode <= pendCode;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    !srcTick |=> !domEn);

  assert_stop_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (actCode == STOP_CODE) |=> !domEn);

  assert_resume_every_R6: assert property (@(posedge clk) disable iff (!rstN)
    (actCode == RESUME_CODE && srcTick) |=> domEn);

  assert_code_at_boundary_R10: assert property (@(posedge clk) disable iff (!rstN)
    (actCode != STOP_CODE && !(srcTick && atLimit)) |=> $stable(actCode));
endmodule

// File: rtl/cdb_datapath.sv
module cdb_datapath
  import cdb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strb,
  output logic [NUM_DOM-1:0] domEn
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    cdb_div_slice u_slice (
      .clk      (clk),
      .rstN     (rstN),
      .srcTick  (strb.tick[d]),
      .pendCode (strb.code[d]),
      .domEn    (domEn[d])
    );
  end
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import cdb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               refPllA,
  input  logic               refExt,
  input  logic               refRtc,
  input  logic               refPllM,
  input  logic               refPllE,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic [NUM_DOM-1:0] domEn
);
  divStrobe_t strb;

  cdb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .refPllA (refPllA),
    .refExt  (refExt),
    .refRtc  (refRtc),
    .refPllM (refPllM),
    .refPllE (refPllE),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .ctlWord (rdData),
    .strb    (strb)
  );

  cdb_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .domEn (domEn)
  );
endmodule

// File: tb/tb_clk_div_bank.sv
module tb_clk_div_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPllA = 0, refExt = 0, refRtc = 0, refPllM = 0, refPllE = 0;
  logic wrEn = 0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  domEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_div_bank dut (
    .clk(clk), .rstN(rstN), .refPllA(refPllA), .refExt(refExt), .refRtc(refRtc),
    .refPllM(refPllM), .refPllE(refPllE), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .domEn(domEn)
  );

  typedef struct packed {
    logic [3:0]  en;
    logic [31:0] rd;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int compared = 0;
  int mismatched = 0;
  string curTag = "R1";

  // reference model state, from the requirements
  logic [31:0] mReg = 32'hAA00_0000;
  int mAct[4] = '{0, 0, 0, 0};
  int mCnt[4] = '{0, 0, 0, 0};
  int lsbTab[4] = '{0, 8, 12, 16};

  function automatic logic pick(input logic [1:0] s, input logic a, input logic b, input logic c);
    case (s)
      2'd1: return a;
      2'd2: return b;
      2'd3: return c;
      default: return 1'b0;
    endcase
  endfunction

  // refs bit order: [0] PLL A, [1] crystal, [2] RTC, [3] PLL M, [4] PLL E
  task automatic drive(input logic [4:0] refs, input logic we, input logic [31:0] wd);
    logic [3:0] t;
    logic [3:0] nen;
    logic mt;
    exp_t e;
    @(negedge clk);
    refPllA = refs[0]; refExt = refs[1]; refRtc = refs[2];
    refPllM = refs[3]; refPllE = refs[4];
    wrEn = we; wrData = wd;
    mt   = pick(mReg[31:30], refs[0], refs[1], refs[2]);
    t[0] = pick(mReg[29:28], mt, refs[3], refs[4]);
    t[1] = pick(mReg[27:26], mt, refs[3], refs[4]);
    t[2] = pick(mReg[25:24], mt, refs[3], refs[2]);
    t[3] = t[2];
    for (int d = 0; d < 4; d++) begin
      int code;
      int lim;
      code = int'(mReg[lsbTab[d] +: 4]);
      lim = (mAct[d] == 15) ? 0 : mAct[d];
      nen[d] = t[d] && (mAct[d] != 14) && (mCnt[d] == lim);
      if (mAct[d] == 14) begin
        mAct[d] = code; mCnt[d] = 0;
      end else if (t[d]) begin
        if (mCnt[d] == lim) begin mCnt[d] = 0; mAct[d] = code; end
        else mCnt[d] = mCnt[d] + 1;
      end
    end
    if (we)
      mReg = wd[22] ? (wd & 32'hFF4F_FF0F)
                    : ((wd & 32'hFF40_0000) | (mReg & 32'h000F_FF0F));
    e.en = nen;
    e.rd = mReg;
    expQ.push_back(e);
    tagQ.push_back(curTag);
  endtask

  task automatic burst(input int n, input logic [4:0] refs, input int every);
    for (int k = 0; k < n; k++)
      drive(((k % every) == 0) ? refs : 5'b0, 1'b0, 32'h0);
  endtask

  task automatic scramble(input int n);
    for (int k = 0; k < n; k++)
      drive(5'((k * 11 + k / 3) ^ (k >> 2)), 1'b0, 32'h0);
  endtask

  task automatic wr(input logic [31:0] w);
    drive(5'b0, 1'b1, w);
  endtask

  // monitor: compares one expected item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        exp_t e;
        string tg;
        e = expQ.pop_front();
        tg = tagQ.pop_front();
        compared++;
        if (domEn !== e.en || rdData !== e.rd) begin
          mismatched++;
          $display("FAIL %s: domEn=%b rdData=%h expected domEn=%b rdData=%h",
                   tg, domEn, rdData, e.en, e.rd);
        end
      end
    end
  end

  bit finished = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compared++;
    if (rdData !== 32'hAA00_0000 || domEn !== 4'b0) begin
      mismatched++;
      $display("FAIL R1: rdData=%h domEn=%b expected rdData=aa000000 domEn=0000", rdData, domEn);
    end
    rstN = 1'b1;
    curTag = "R1";
    burst(4, 5'h1F, 1);

    curTag = "R2";
    wr(32'hFFFF_FFFF);
    burst(3, 5'h00, 1);
    wr(32'h0000_0000);
    wr(32'h0040_0000);
    burst(2, 5'h00, 1);

    curTag = "R3";
    wr(32'h5512_3456);
    burst(3, 5'h1F, 1);

    curTag = "R4";
    wr(32'h9B4F_D200);
    burst(40, 5'b01110, 1);
    burst(60, 5'b01110, 3);
    scramble(120);
    wr(32'hAA4D_7A36);
    scramble(150);

    curTag = "R7";
    for (int ms = 0; ms < 4; ms++) begin
      wr({2'(ms), 6'b010101, 8'h4F, 16'hFF0F});
      for (int r = 0; r < 5; r++) burst(6, 5'(1 << r), 2);
    end

    curTag = "R8";
    for (int cs = 0; cs < 4; cs++) begin
      wr({2'b10, 2'(cs), 2'(cs), 2'b00, 8'h4F, 16'hFF0F});
      for (int r = 0; r < 5; r++) burst(6, 5'(1 << r), 2);
    end

    curTag = "R9";
    for (int bs = 0; bs < 4; bs++) begin
      wr({2'b10, 2'b01, 2'b01, 2'(bs), 8'h42, 16'h1F0F});
      for (int r = 0; r < 5; r++) burst(10, 5'(1 << r), 1);
    end

    curTag = "R5";
    wr(32'hAA4E_100E);
    burst(30, 5'h1F, 1);

    curTag = "R6";
    wr(32'hAA4F_FF0F);
    burst(20, 5'h1F, 2);

    curTag = "R10";
    wr(32'hAA40_0505);
    burst(8, 5'h1F, 1);
    wr(32'hAA40_0501);
    burst(20, 5'h1F, 1);
    wr(32'hAA40_050E);
    burst(5, 5'h1F, 1);
    drive(5'h1F, 1'b1, 32'hAA40_0503);
    burst(20, 5'h1F, 1);

    curTag = "R3";
    drive(5'h1F, 1'b1, 32'hAA00_0000);
    burst(24, 5'h1F, 1);

    burst(2, 5'h00, 1);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule